// File: doc/BRIEF.md
# Display PLL Divider Search Engine

This block picks the settings of a display clock PLL. After a start pulse it captures a reference frequency and a wanted pixel clock, both in hertz. It then walks through every setting of three codes: a pre-divider code M, a feedback multiplier code N and a post-divider code F. For each setting it works out the frequency the PLL would produce and keeps the setting that lands nearest the wanted clock. Settings whose intermediate frequency falls outside the oscillator's window are skipped. Settings whose output reaches the output ceiling are not considered.

All arithmetic goes through one shared multi-cycle divider. The divider retires a parameterised number of quotient bits per cycle. When the walk is over, the engine raises a one-cycle done pulse and presents the chosen codes, the frequency they give and the absolute error. Those results stay where they are until the next search completes. The walk visits low pre-divider codes first and high multiplier codes first, because that favours low jitter. Only a strictly better error replaces the current pick, so on a tie the setting seen earlier is kept.

Top module: `dpll_search_engine`

## Requirements
- R1: While reset is held and after it is released, done is low, all three codes and the output frequency are zero, and the error is all ones (0xFFFFFFFF).
- R2: The frequency of a setting is floor(floor(fin × (N+1) / (M+1)) / (F+1)) in integer arithmetic with no overflow. The reported error is the absolute difference between the reported frequency and the target captured at start.
- R3: Settings are visited with M rising from 0 to 3 as the outermost loop, N falling from 119 to 39 inside it, and F rising from 1 to 31 as the innermost loop. A setting replaces the current pick only when its error is strictly smaller, so the earliest setting in this order wins a tie.
- R4: An (M, N) pair is skipped for every F when floor(fin × (N+1) / (M+1)) is below 1000 or above 2,048,000,000.
- R5: A setting whose frequency is 400,000,000 Hz or more is never picked. Every reported pick has a frequency below that value.
- R6: When no setting qualifies, the result is all three codes zero, frequency zero and error 0xFFFFFFFF.
- R7: done is high for exactly one cycle at the end of each search.
- R8: The result outputs change only in a cycle in which done is high. They hold their values while start stays low.
- R9: A start pulse that arrives while a search is running is ignored, and the running search finishes with the inputs it captured. A start pulse in the same cycle as done is accepted and begins a new search.
- R10: A reported pick has N between 39 and 119 and F between 1 and 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a search when the engine is idle |
| fin_hz | input | 32 | Reference frequency in Hz, captured at start |
| target_hz | input | 32 | Wanted output frequency in Hz, captured at start |
| m_code | output | 2 | Chosen pre-divider code |
| n_code | output | 7 | Chosen feedback multiplier code |
| fdpll_code | output | 5 | Chosen post-divider code |
| fout_hz | output | 32 | Frequency produced by the chosen codes |
| err_hz | output | 32 | Absolute error of the chosen frequency |
| done | output | 1 | One-cycle pulse when the results are updated |

## Verification
Two events can meet in one cycle: the done pulse that publishes a result and a start pulse that opens the next search. The bench holds start high in exactly the cycle it sees done. It then checks that the result just published belongs to the first search and that the next done carries the result for the second set of inputs. A start raised partway through a search is judged by comparing the published result with the one expected for the first inputs, not the second. Every expected pick comes from an independent walk of the loop order in the bench.

// File: rtl/dpll_search_pkg.sv
package dpll_search_pkg;

    localparam int FREQ_W = 32;
    localparam int M_W    = 2;
    localparam int N_W    = 7;
    localparam int F_W    = 5;
    localparam int DEN_W  = 6;              // holds a code plus one, up to 32
    localparam int PROD_W = FREQ_W + N_W + 1;

    localparam logic [M_W-1:0] M_FIRST = 2'd0;
    localparam logic [M_W-1:0] M_LAST  = 2'd3;
    localparam logic [N_W-1:0] N_FIRST = 7'd119;
    localparam logic [N_W-1:0] N_LAST  = 7'd39;
    localparam logic [F_W-1:0] F_FIRST = 5'd1;
    localparam logic [F_W-1:0] F_LAST  = 5'd31;

    localparam logic [FREQ_W-1:0] VCO_FLOOR = 32'd1000;
    localparam logic [FREQ_W-1:0] VCO_ROOF  = 32'd2048000000;
    localparam logic [FREQ_W-1:0] OUT_ROOF  = 32'd400000000;

    typedef struct packed {
        logic [M_W-1:0]    m;
        logic [N_W-1:0]    n;
        logic [F_W-1:0]    f;
        logic [FREQ_W-1:0] freq;
        logic [FREQ_W-1:0] err;
    } pll_pick_t;

    localparam pll_pick_t NO_PICK = '{m: '0, n: '0, f: '0, freq: '0, err: '1};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAIR_GO,
        ST_PAIR_WAIT,
        ST_FD_GO,
        ST_FD_WAIT,
        ST_STEP,
        ST_FINISH
    } search_state_t;

    function automatic logic [FREQ_W-1:0] freq_gap(input logic [FREQ_W-1:0] a,
                                                   input logic [FREQ_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 6,
    parameter int STEPS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quot,
    output logic             valid
);
    localparam int ROUNDS = NUM_W / STEPS;
    localparam int CNT_W  = $clog2(ROUNDS + 1);

    logic [NUM_W-1:0] shq, nxt_shq;
    logic [DEN_W-1:0] rem, nxt_rem, den_q;
    logic [CNT_W-1:0] cnt;
    logic             busy, valid_q;
    logic [DEN_W:0]   ext;

    // Several restoring steps per cycle: shift in one dividend bit, subtract if it fits.
    always_comb begin
        nxt_shq = shq;
        nxt_rem = rem;
        ext     = '0;
        for (int i = 0; i < STEPS; i++) begin
            ext     = {nxt_rem, nxt_shq[NUM_W-1]};
            nxt_shq = {nxt_shq[NUM_W-2:0], 1'b0};
            if (ext >= {1'b0, den_q}) begin
                ext        = ext - {1'b0, den_q};
                nxt_shq[0] = 1'b1;
            end
            nxt_rem = ext[DEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shq     <= '0;
            rem     <= '0;
            den_q   <= '0;
            cnt     <= '0;
            busy    <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go) begin
                shq   <= num;
                rem   <= '0;
                den_q <= den;
                cnt   <= CNT_W'(ROUNDS);
                busy  <= 1'b1;
            end else if (busy) begin
                shq <= nxt_shq;
                rem <= nxt_rem;
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy    <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quot  = shq;
    assign valid = valid_q;

endmodule

// File: rtl/pll_cand_judge.sv
module pll_cand_judge
    import dpll_search_pkg::*;
#(
    parameter int Q_W = 40
) (
    input  logic [Q_W-1:0]    quot,
    input  logic [FREQ_W-1:0] target,
    input  logic [FREQ_W-1:0] best_err,
    output logic              pair_ok,
    output logic              cand_ok,
    output logic [FREQ_W-1:0] gap
);
    logic below_roof;

    always_comb begin
        pair_ok    = (quot >= Q_W'(VCO_FLOOR)) && (quot <= Q_W'(VCO_ROOF));
        below_roof = quot < Q_W'(OUT_ROOF);
        gap        = freq_gap(quot[FREQ_W-1:0], target);
        cand_ok    = below_roof && (gap < best_err);
    end

endmodule

// File: rtl/dpll_search_engine.sv
module dpll_search_engine
    import dpll_search_pkg::*;
#(
    parameter int DIV_STEPS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] fin_hz,
    input  logic [FREQ_W-1:0] target_hz,
    output logic [M_W-1:0]    m_code,
    output logic [N_W-1:0]    n_code,
    output logic [F_W-1:0]    fdpll_code,
    output logic [FREQ_W-1:0] fout_hz,
    output logic [FREQ_W-1:0] err_hz,
    output logic              done
);
    localparam int Q_W = ((PROD_W + DIV_STEPS - 1) / DIV_STEPS) * DIV_STEPS;

    search_state_t     state;
    logic [FREQ_W-1:0] fin_q, tgt_q;
    logic [M_W-1:0]    m_q;
    logic [N_W-1:0]    n_q;
    logic [F_W-1:0]    f_q;
    logic [Q_W-1:0]    vco_q;
    pll_pick_t         best, res;
    logic              done_q;
    logic              idle;

    logic              div_go, div_valid, in_pair;
    logic [Q_W-1:0]    div_num, div_quot;
    logic [DEN_W-1:0]  div_den;
    logic [N_W:0]      n_plus;
    logic              pair_ok, cand_ok;
    logic [FREQ_W-1:0] gap;

    assign idle    = (state == ST_IDLE);
    assign in_pair = (state == ST_PAIR_GO);
    assign div_go  = in_pair || (state == ST_FD_GO);
    assign n_plus  = {1'b0, n_q} + (N_W+1)'(1);
    assign div_num = in_pair ? (Q_W'(fin_q) * Q_W'(n_plus)) : vco_q;
    assign div_den = in_pair ? (DEN_W'(m_q) + DEN_W'(1)) : (DEN_W'(f_q) + DEN_W'(1));

    pll_seq_divider #(.NUM_W(Q_W), .DEN_W(DEN_W), .STEPS(DIV_STEPS)) u_div (
        .clk   (clk),
        .rst   (rst),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .quot  (div_quot),
        .valid (div_valid)
    );

    pll_cand_judge #(.Q_W(Q_W)) u_judge (
        .quot     (div_quot),
        .target   (tgt_q),
        .best_err (best.err),
        .pair_ok  (pair_ok),
        .cand_ok  (cand_ok),
        .gap      (gap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            fin_q  <= '0;
            tgt_q  <= '0;
            m_q    <= '0;
            n_q    <= '0;
            f_q    <= '0;
            vco_q  <= '0;
            best   <= NO_PICK;
            res    <= NO_PICK;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        fin_q <= fin_hz;
                        tgt_q <= target_hz;
                        m_q   <= M_FIRST;
                        n_q   <= N_FIRST;
                        best  <= NO_PICK;
                        state <= ST_PAIR_GO;
                    end
                end
                ST_PAIR_GO: state <= ST_PAIR_WAIT;
                ST_PAIR_WAIT: begin
                    if (div_valid) begin
                        vco_q <= div_quot;
                        if (pair_ok) begin
                            f_q   <= F_FIRST;
                            state <= ST_FD_GO;
                        end else begin
                            state <= ST_STEP;
                        end
                    end
                end
                ST_FD_GO: state <= ST_FD_WAIT;
                ST_FD_WAIT: begin
                    if (div_valid) begin
                        if (cand_ok) begin
                            best <= '{m: m_q, n: n_q, f: f_q,
                                      freq: div_quot[FREQ_W-1:0], err: gap};
                        end
                        if (f_q == F_LAST) begin
                            state <= ST_STEP;
                        end else begin
                            f_q   <= f_q + F_W'(1);
                            state <= ST_FD_GO;
                        end
                    end
                end
                ST_STEP: begin
                    if (n_q == N_LAST) begin
                        if (m_q == M_LAST) begin
                            state <= ST_FINISH;
                        end else begin
                            m_q   <= m_q + M_W'(1);
                            n_q   <= N_FIRST;
                            state <= ST_PAIR_GO;
                        end
                    end else begin
                        n_q   <= n_q - N_W'(1);
                        state <= ST_PAIR_GO;
                    end
                end
                ST_FINISH: begin
                    res    <= best;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign m_code     = res.m;
    assign n_code     = res.n;
    assign fdpll_code = res.f;
    assign fout_hz    = res.freq;
    assign err_hz     = res.err;
    assign done       = done_q;

endmodule

// File: rtl/dpll_search_checker.sv
module dpll_search_checker
    import dpll_search_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              idle,
    input logic [FREQ_W-1:0] target_hz,
    input logic [M_W-1:0]    m_code,
    input logic [N_W-1:0]    n_code,
    input logic [F_W-1:0]    fdpll_code,
    input logic [FREQ_W-1:0] fout_hz,
    input logic [FREQ_W-1:0] err_hz,
    input logic              done
);
    logic [FREQ_W-1:0] seen_target;

    always_ff @(posedge clk) begin
        if (rst) seen_target <= '0;
        else if (idle && start) seen_target <= target_hz;
    end

    // R7
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({m_code, n_code, fdpll_code, fout_hz, err_hz}));

    // R5
    a_r5_out_ceiling: assert property (@(posedge clk) disable iff (rst)
        (done && err_hz != '1) |-> (fout_hz < OUT_ROOF));

    // R6
    a_r6_empty_result: assert property (@(posedge clk) disable iff (rst)
        (done && err_hz == '1) |-> (m_code == '0 && n_code == '0 &&
                                    fdpll_code == '0 && fout_hz == '0));

    // R10
    a_r10_code_range: assert property (@(posedge clk) disable iff (rst)
        (done && err_hz != '1) |-> (n_code >= N_LAST && n_code <= N_FIRST &&
                                    fdpll_code >= F_FIRST));

    // R2
    a_r2_err_matches: assert property (@(posedge clk) disable iff (rst)
        (done && err_hz != '1) |-> (err_hz == freq_gap(fout_hz, seen_target)));

endmodule

bind dpll_search_engine dpll_search_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .idle       (idle),
    .target_hz  (target_hz),
    .m_code     (m_code),
    .n_code     (n_code),
    .fdpll_code (fdpll_code),
    .fout_hz    (fout_hz),
    .err_hz     (err_hz),
    .done       (done)
);

// File: tb/dpll_search_engine_test.sv
module dpll_search_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] fin_hz = '0;
    logic [31:0] target_hz = '0;
    logic [1:0]  m_code;
    logic [6:0]  n_code;
    logic [4:0]  fdpll_code;
    logic [31:0] fout_hz;
    logic [31:0] err_hz;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpll_search_engine uut (
        .clk(clk), .rst(rst), .start(start), .fin_hz(fin_hz), .target_hz(target_hz),
        .m_code(m_code), .n_code(n_code), .fdpll_code(fdpll_code),
        .fout_hz(fout_hz), .err_hz(err_hz), .done(done)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Independent walk of the stated loop order (R2, R3, R4, R5, R6).
    task automatic ref_search(input longint unsigned fin, input longint unsigned tgt,
                              output longint em, output longint en, output longint ef,
                              output longint efreq, output longint eerr);
        longint unsigned best = 64'hFFFF_FFFF;
        em = 0; en = 0; ef = 0; efreq = 0; eerr = 64'hFFFF_FFFF;
        for (int m = 0; m <= 3; m++) begin
            for (int n = 119; n >= 39; n--) begin
                longint unsigned vco = fin * longint'(n + 1) / longint'(m + 1);
                if (vco < 1000 || vco > 2048000000) continue;
                for (int f = 1; f <= 31; f++) begin
                    longint unsigned o = vco / longint'(f + 1);
                    longint unsigned d;
                    if (o >= 400000000) continue;
                    d = (o > tgt) ? o - tgt : tgt - o;
                    if (d < best) begin
                        best = d; em = m; en = n; ef = f; efreq = o; eerr = d;
                    end
                end
            end
        end
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [31:0] fin, input logic [31:0] tgt);
        fin_hz = fin; target_hz = tgt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic compare(input string req, input logic [31:0] fin, input logic [31:0] tgt);
        longint em, en, ef, efreq, eerr;
        ref_search(fin, tgt, em, en, ef, efreq, eerr);
        check(req, "m_code", m_code, em);
        check(req, "n_code", n_code, en);
        check(req, "fdpll_code", fdpll_code, ef);
        check(req, "fout_hz", fout_hz, efreq);
        check(req, "err_hz", err_hz, eerr);
    endtask

    task automatic run_and_compare(input string req, input logic [31:0] fin, input logic [31:0] tgt);
        pulse_start(fin, tgt);
        wait_done();
        compare(req, fin, tgt);
        @(negedge clk);
        check("R7", "done after one cycle", done, 0);
    endtask

    // R1: reset values
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "done in reset", done, 0);
        check("R1", "err in reset", err_hz, 32'hFFFF_FFFF);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "done after reset", done, 0);
        check("R1", "m_code", m_code, 0);
        check("R1", "n_code", n_code, 0);
        check("R1", "fdpll_code", fdpll_code, 0);
        check("R1", "fout_hz", fout_hz, 0);
        check("R1", "err_hz", err_hz, 32'hFFFF_FFFF);
    endtask

    // R2, R4: typical pixel clock
    task automatic t_typical();
        run_and_compare("R2", 32'd100000000, 32'd148500000);
        check("R2", "err gap", err_hz,
              (fout_hz > 148500000) ? fout_hz - 148500000 : 148500000 - fout_hz);
    endtask

    // R3, R4: exact hit reached by several settings, earliest kept
    task automatic t_tie_order();
        run_and_compare("R3", 32'd100000000, 32'd200000000);
        check("R3", "tie m", m_code, 1);
        check("R3", "tie n", n_code, 39);
        check("R3", "tie f", fdpll_code, 9);
        check("R3", "tie err", err_hz, 0);
    endtask

    // R5: target above the ceiling
    task automatic t_ceiling();
        run_and_compare("R5", 32'd100000000, 32'd450000000);
        check("R5", "below ceiling", (fout_hz < 400000000) ? 1 : 0, 1);
    endtask

    // R6, R4: nothing qualifies at either extreme
    task automatic t_empty();
        run_and_compare("R6", 32'd1, 32'd1000);
        check("R6", "low fin err", err_hz, 32'hFFFF_FFFF);
        check("R6", "low fin n", n_code, 0);
        run_and_compare("R6", 32'hFFFF_FFFF, 32'd50000000);
        check("R6", "high fin err", err_hz, 32'hFFFF_FFFF);
        check("R6", "high fin freq", fout_hz, 0);
    endtask

    // R9: start during a running search is ignored
    task automatic t_start_busy();
        pulse_start(32'd100000000, 32'd148500000);
        repeat (200) @(negedge clk);
        pulse_start(32'd1, 32'd5);
        wait_done();
        compare("R9", 32'd100000000, 32'd148500000);
        @(negedge clk);
    endtask

    // R9, R8, R10: start in the same cycle as done, then hold
    task automatic t_start_on_done();
        logic [31:0] held_f, held_e;
        logic [6:0]  held_n;
        pulse_start(32'd200000000, 32'd25000000);
        wait_done();
        fin_hz = 32'd150000000; target_hz = 32'd74250000; start = 1'b1;
        compare("R9", 32'd200000000, 32'd25000000);
        @(negedge clk);
        start = 1'b0;
        fin_hz = 32'd7; target_hz = 32'd9;
        wait_done();
        compare("R9", 32'd150000000, 32'd74250000);
        check("R10", "n in range", (n_code >= 39 && n_code <= 119) ? 1 : 0, 1);
        check("R10", "f in range", (fdpll_code >= 1) ? 1 : 0, 1);
        held_f = fout_hz; held_e = err_hz; held_n = n_code;
        repeat (300) @(negedge clk);
        check("R8", "fout held", fout_hz, held_f);
        check("R8", "err held", err_hz, held_e);
        check("R8", "n held", n_code, held_n);
        check("R7", "no stray done", done, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_typical();
        t_tie_order();
        t_ceiling();
        t_empty();
        t_start_busy();
        t_start_on_done();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule